// File: doc/BRIEF.md
# Memory Thermal Phase Monitor

This block watches the die temperature of a stacked memory device and sorts each new reading into one of three operating phases: normal, warm and hot. A reading arrives as an unsigned whole number of degrees Celsius with a one-cycle valid strobe. From the phase the block derives two things. The first is a level signal that tells the memory controller to run the DRAM at reduced frequency. The second is a one-cycle warning event, with the new phase code attached, that is forwarded to the host so that it can reduce how much work it offloads to memory.

Phases rise as soon as a reading reaches a boundary. They fall only after the reading has dropped a hysteresis margin below that boundary, so a sensor hovering at a boundary does not make the phase chatter. A reading beyond the upper operating limit sets a sticky over-limit flag. The flag stays set until software pulses a clear input.

Top module: `thermal_phase_mon`

## Requirements
- R1: Out of reset the phase is normal (code 0), the derate output is low, no warning is issued and the over-limit flag is clear.
- R2: On a valid reading the phase moves up to hot (code 2) for 95 °C or more, or to warm (code 1) for 85 to 94 °C, when that is above the present phase. The new phase is visible one cycle after the sample. A single reading may jump directly from normal to hot.
- R3: When the valid strobe is low, the temperature input is ignored and the phase, warning and over-limit outputs do not change because of it.
- R4: A falling phase needs hysteresis. Warm drops to normal only on a reading below 83 °C. Hot drops to warm only below 93 °C, and drops directly to normal below 83 °C. Readings between a boundary and its hysteresis point hold the present phase.
- R5: The frequency-derate output is high exactly while the phase is warm or hot.
- R6: A warning pulse lasts one cycle and appears in the same cycle as a rise of the phase, carrying the new phase code. No pulse is issued for a repeated reading in the same phase or for a fall in phase.
- R7: A valid reading above 105 °C sets the over-limit flag one cycle later. The flag holds until the clear input is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: A clear pulse without an over-limit reading in the same cycle lowers the flag one cycle later. The phase does not change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | Temperature reading strobe |
| temp_code | input | TEMP_W | Reading, unsigned °C |
| ovl_clear | input | 1 | Software clear of the over-limit flag |
| phase_o | output | 2 | Current phase: 0 normal, 1 warm, 2 hot |
| derate_en | output | 1 | DRAM frequency reduction request |
| warn_pulse | output | 1 | One-cycle thermal warning event |
| warn_phase | output | 2 | Phase code carried with the warning |
| over_limit | output | 1 | Sticky over-limit flag |

## Verification
Two functions can act in the same cycle. A single reading above 105 °C taken from the normal phase produces both the escalation warning to hot and the setting of the over-limit flag. Separately, a clear pulse can meet a fresh over-limit reading. The bench provokes both cases on purpose, and again at random during a long sweep, and compares every output on every cycle against a behavioural model. In the second case the model expects the flag to remain set.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  typedef enum logic [1:0] {
    PH_NORMAL = 2'd0,
    PH_WARM   = 2'd1,
    PH_HOT    = 2'd2
  } phase_t;

  // Band of a reading for a given pair of boundaries (inclusive lower edges).
  function automatic phase_t band_of(input int unsigned t,
                                     input int unsigned warm_edge,
                                     input int unsigned hot_edge);
    if (t >= hot_edge) return PH_HOT;
    if (t >= warm_edge) return PH_WARM;
    return PH_NORMAL;
  endfunction

  // Rising band applies at once; otherwise the hysteresis band decides.
  function automatic phase_t settle(input phase_t cur, input phase_t up_band,
                                    input phase_t down_band);
    if (up_band >= cur) return up_band;
    return down_band;
  endfunction
endpackage

// File: rtl/phase_classifier.sv
module phase_classifier
  import thermal_pkg::*;
#(
  parameter int unsigned TEMP_W  = 8,
  parameter int unsigned WARM_AT = 85,
  parameter int unsigned HOT_AT  = 95,
  parameter int unsigned HYST    = 2
) (
  input  logic [TEMP_W-1:0] temp,
  output phase_t            up_band,
  output phase_t            down_band
);
  localparam int unsigned PAD       = 32 - TEMP_W;
  localparam int unsigned WARM_DOWN = WARM_AT - HYST;
  localparam int unsigned HOT_DOWN  = HOT_AT - HYST;

  logic [31:0] t_wide;
  assign t_wide = {{PAD{1'b0}}, temp};

  always_comb begin
    up_band   = band_of(t_wide, WARM_AT, HOT_AT);
    down_band = band_of(t_wide, WARM_DOWN, HOT_DOWN);
  end
endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
  import thermal_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sample_valid,
  input  phase_t up_band,
  input  phase_t down_band,
  output phase_t phase_q,
  output logic   escalate,
  output logic   warn_q,
  output phase_t warn_code_q
);
  phase_t next_phase;

  always_comb begin
    next_phase = settle(phase_q, up_band, down_band);
    escalate   = sample_valid && (next_phase > phase_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_NORMAL;
      warn_q      <= 1'b0;
      warn_code_q <= PH_NORMAL;
    end else begin
      warn_q <= escalate;
      if (sample_valid) phase_q <= next_phase;
      if (escalate) warn_code_q <= next_phase;
    end
  end
endmodule

// File: rtl/overlimit_latch.sv
module overlimit_latch #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned LIMIT  = 105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [TEMP_W-1:0] temp,
  input  logic              clear,
  output logic              hit,
  output logic              flag_q
);
  localparam logic [TEMP_W-1:0] LIM = TEMP_W'(LIMIT);

  assign hit = sample_valid && (temp > LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clear) flag_q <= 1'b0;
  end
endmodule

// File: rtl/thermal_phase_mon.sv
module thermal_phase_mon
  import thermal_pkg::*;
#(
  parameter int unsigned TEMP_W  = 8,
  parameter int unsigned WARM_AT = 85,
  parameter int unsigned HOT_AT  = 95,
  parameter int unsigned LIMIT   = 105,
  parameter int unsigned HYST    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              ovl_clear,
  output logic [1:0]        phase_o,
  output logic              derate_en,
  output logic              warn_pulse,
  output logic [1:0]        warn_phase,
  output logic              over_limit
);
  phase_t up_band, down_band, phase_q, warn_code_q;
  logic   escalate_w;
  logic   over_hit;

  phase_classifier #(
    .TEMP_W(TEMP_W), .WARM_AT(WARM_AT), .HOT_AT(HOT_AT), .HYST(HYST)
  ) u_cls (
    .temp(temp_code), .up_band(up_band), .down_band(down_band)
  );

  phase_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .sample_valid(temp_valid),
    .up_band(up_band), .down_band(down_band), .phase_q(phase_q),
    .escalate(escalate_w), .warn_q(warn_pulse), .warn_code_q(warn_code_q)
  );

  overlimit_latch #(.TEMP_W(TEMP_W), .LIMIT(LIMIT)) u_ovl (
    .clk(clk), .rst_n(rst_n), .sample_valid(temp_valid), .temp(temp_code),
    .clear(ovl_clear), .hit(over_hit), .flag_q(over_limit)
  );

  assign phase_o    = phase_q;
  assign warn_phase = warn_code_q;
  assign derate_en  = (phase_q != PH_NORMAL);
endmodule

// File: rtl/thermal_phase_chk.sv
module thermal_phase_chk #(
  parameter int unsigned TEMP_W  = 8,
  parameter int unsigned WARM_AT = 85,
  parameter int unsigned HOT_AT  = 95,
  parameter int unsigned HYST    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              temp_valid,
  input logic [TEMP_W-1:0] temp_code,
  input logic              ovl_clear,
  input logic [1:0]        phase_o,
  input logic              derate_en,
  input logic              warn_pulse,
  input logic [1:0]        warn_phase,
  input logic              over_limit,
  input logic              escalate_w,
  input logic              over_hit
);
  localparam logic [TEMP_W-1:0] HOT_T  = TEMP_W'(HOT_AT);
  localparam logic [TEMP_W-1:0] WARM_D = TEMP_W'(WARM_AT - HYST);
  localparam logic [TEMP_W-1:0] HOT_D  = TEMP_W'(HOT_AT - HYST);

  // R2
  hot_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid && (temp_code >= HOT_T) |=> phase_o == 2'd2);

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_valid |=> $stable(phase_o));

  // R4
  cool_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd0) && temp_valid && (temp_code >= WARM_D) |=> phase_o != 2'd0);

  // R4
  hot_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2) && temp_valid && (temp_code >= HOT_D) |=> phase_o == 2'd2);

  // R6
  warn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    escalate_w |=> warn_pulse && (phase_o > $past(phase_o)) && (warn_phase == phase_o));

  // R6
  warn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> (phase_o != $past(phase_o)));

  // R7
  ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit && !ovl_clear |=> over_limit);

  // R7
  ovl_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_hit |=> over_limit);

  // R5
  derate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(derate_en) |-> $past(temp_valid));
endmodule

bind thermal_phase_mon thermal_phase_chk #(
  .TEMP_W(TEMP_W), .WARM_AT(WARM_AT), .HOT_AT(HOT_AT), .HYST(HYST)
) u_chk (.*);

// File: tb/sim_thermal_phase_mon.sv
module sim_thermal_phase_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       temp_valid = 1'b0;
  logic [7:0] temp_code = 8'd0;
  logic       ovl_clear = 1'b0;
  logic [1:0] phase_o;
  logic       derate_en, warn_pulse, over_limit;
  logic [1:0] warn_phase;

  int vectors = 0;
  int misses = 0;
  string cur_tag = "R1";
  bit done = 0;

  // behavioural reference state
  int m_phase = 0;
  bit m_warn = 0;
  int m_wcode = 0;
  bit m_ovl = 0;

  always #5 clk = ~clk;

  thermal_phase_mon u0 (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_code(temp_code),
    .ovl_clear(ovl_clear), .phase_o(phase_o), .derate_en(derate_en),
    .warn_pulse(warn_pulse), .warn_phase(warn_phase), .over_limit(over_limit)
  );

  always @(posedge clk) begin
    int t, rise_to, fall_to;
    if (!rst_n) begin
      m_phase = 0; m_warn = 0; m_wcode = 0; m_ovl = 0;
    end else begin
      m_warn = 0;
      if (temp_valid) begin
        t = int'(temp_code);
        rise_to = 0;
        if (t >= 85) rise_to = 1;
        if (t >= 95) rise_to = 2;
        fall_to = 0;
        if (t > 82) fall_to = 1;
        if (t > 92) fall_to = 2;
        if (rise_to > m_phase) begin
          m_phase = rise_to; m_warn = 1; m_wcode = rise_to;
        end else if (fall_to < m_phase) begin
          m_phase = fall_to;
        end
      end
      if (temp_valid && temp_code > 8'd105) m_ovl = 1;
      else if (ovl_clear) m_ovl = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (int'(phase_o) != m_phase) begin
        misses++;
        $display("FAIL R2 R4 [%s] phase got %0d exp %0d", cur_tag, phase_o, m_phase);
      end
      if (derate_en !== (m_phase != 0)) begin
        misses++;
        $display("FAIL R5 [%s] derate got %0b exp %0b", cur_tag, derate_en, m_phase != 0);
      end
      if (warn_pulse !== m_warn) begin
        misses++;
        $display("FAIL R6 [%s] warn got %0b exp %0b", cur_tag, warn_pulse, m_warn);
      end else if (m_warn && int'(warn_phase) != m_wcode) begin
        misses++;
        $display("FAIL R6 [%s] warn code got %0d exp %0d", cur_tag, warn_phase, m_wcode);
      end
      if (over_limit !== m_ovl) begin
        misses++;
        $display("FAIL R7 [%s] over-limit got %0b exp %0b", cur_tag, over_limit, m_ovl);
      end
    end
  end

  task automatic step(input bit v, input int t, input bit c, input string tag);
    cur_tag = tag;
    temp_valid = v;
    temp_code = 8'(t);
    ovl_clear = c;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                // R1 reset state compared above
    step(1, 40, 0, "R2 normal");
    step(1, 70, 0, "R2 normal");
    step(1, 85, 0, "R2 warm edge");
    step(1, 90, 0, "R6 repeat");
    step(0, 100, 0, "R3 idle");  // ignored reading
    step(0, 0, 0, "R3 idle");
    step(1, 84, 0, "R4 hold");
    step(1, 83, 0, "R4 hold");
    step(1, 82, 0, "R4 fall");
    step(1, 95, 0, "R2 jump hot");
    step(1, 93, 0, "R4 hot hold");
    step(1, 92, 0, "R4 hot fall");
    step(1, 100, 0, "R6 rewarn");
    step(1, 80, 0, "R4 hot to normal");
    step(1, 106, 0, "R7 coincide");
    step(1, 105, 0, "R7 at limit");
    step(0, 0, 0, "R7 sticky");
    step(0, 0, 1, "R8 clear");
    step(0, 0, 0, "R8 cleared");
    step(1, 110, 1, "R7 set wins");
    step(0, 0, 0, "R7 set wins");
    step(1, 60, 1, "R8 clear");
    step(0, 0, 0, "R8 cleared");
    for (int i = 0; i < 2000; i++)
      step($urandom_range(3, 0) != 0, int'($urandom_range(115, 60)),
           $urandom_range(7, 0) == 0, "sweep");
    step(0, 0, 0, "tail");
    finish_run();
  end
endmodule